// File: doc/BRIEF.md
# Backward Recursion and Extrinsic Scaling Unit

This unit forms the second half of a soft-in soft-out decoder for an eight-state recursive systematic trellis. A forward recursion elsewhere pushes, step by step, an eight-entry vector of forward state metrics together with the three soft inputs of that step: a-priori, systematic and parity. After a whole sliding window has been pushed, a start pulse makes the unit pop the stack from the last step back to the first. On each step it runs eight add-compare-select cells for the backward metrics. It forms a max-log posterior LLR from forward, branch and backward terms. It subtracts the a-priori and systematic inputs, scales the result by a selectable factor below one and emits a saturated 7-bit extrinsic value tagged with its step index.

Each window's backward recursion needs a starting vector at its right border. Three sources are possible. In the first iteration it is all zeros. For the window that ends the code block it is a terminated vector. In every other case it is the vector this unit saved at that border in the previous iteration. At the end of each pass, the backward vector reached at the window's left border is written into a small border store for use in the next iteration.

The control is a four-state machine. ST_IDLE accepts pushes and, on a start with a non-empty stack, takes transition ACCEPT to ST_SEED. ST_SEED loads the seed vector and takes LOAD to ST_RUN. ST_RUN processes one step per cycle, taking STEP back to itself while steps remain and LAST to ST_SAVE after step 0. ST_SAVE writes the border store, empties the stack and takes STORE to ST_IDLE.

Top module: `beta_llr_unit`

## Requirements
- R1: The trellis state m has bits m[2:0]. For input bit j the feedback bit is a = j ^ m[1] ^ m[0], the successor state is {a, m[2], m[1]} and the parity bit is a ^ m[2] ^ m[0]. The branch metric adds a-priori plus systematic when j is 1 and adds parity when the parity bit is 1. Each backward metric is the larger of the two sums, branch metric plus the successor's backward metric. The vector is renormalised by subtracting the state-0 entry, which leaves every output unchanged.
- R2: A start accepted in ST_IDLE with N stored steps produces N outputs on consecutive cycles. Their step tags run from N-1 down to 0, and the first ext_valid is visible after the second rising edge following the edge that sampled start.
- R3: The posterior LLR is the maximum over the eight input-1 transitions of forward plus branch plus backward metric, minus the same maximum over input-0 transitions. The extrinsic value is that LLR minus the a-priori and systematic inputs of the step.
- R4: scale_sel 0, 1, 2 and 3 multiply the extrinsic value by 10/16, 11/16, 12/16 and 13/16. Codes 4 to 7 act as code 3. The product is rounded toward zero.
- R5: The scaled value is clamped to the range -64 to 63.
- R6: With seed_first set and seed_tail clear, the right-border backward vector is all zeros.
- R7: With seed_tail set, the right-border vector is 0 for state 0 and -2^(MW-3) for the other states, whatever seed_first is.
- R8: With both seed flags clear, the right-border vector is the one saved at the end of the last pass that used save_idx equal to this load_idx. Every pass saves its left-border vector at save_idx.
- R9: A push is taken only in ST_IDLE and only when start is low. A push raised while busy, or in the same cycle as start, stores nothing.
- R10: A start with an empty stack is ignored, and busy stays low.
- R11: The stack holds at most DEPTH steps, and pushes beyond that are dropped.
- R12: After reset busy and ext_valid are low, and every entry of the border store is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Stores one step on the stack |
| push_alpha | input | 8*MW | Forward metrics of the step, state m at bits [m*MW +: MW] |
| push_apri | input | LW | A-priori soft input, signed |
| push_sys | input | LW | Systematic soft input, signed |
| push_par | input | LW | Parity soft input, signed |
| start | input | 1 | Begins a backward pass over the stored steps |
| seed_first | input | 1 | First iteration: zero seed (sampled with start) |
| seed_tail | input | 1 | Window ends the block: terminated seed (sampled with start) |
| load_idx | input | $clog2(NBORD) | Border entry read as seed (sampled with start) |
| save_idx | input | $clog2(NBORD) | Border entry written at pass end (sampled with start) |
| scale_sel | input | 3 | Extrinsic scale code (sampled with start) |
| busy | output | 1 | High outside ST_IDLE |
| ext_valid | output | 1 | Extrinsic output strobe |
| ext_value | output | OW | Scaled, saturated extrinsic value, signed |
| ext_step | output | $clog2(DEPTH) | Step index of ext_value |

## Verification
Two pairs of functions can fall in the same cycle: a push with a start, and a push with a running pass. The bench provokes the first by raising push_valid with distinct data in the very cycle that carries start. It provokes the second by holding push_valid high for the whole of a pass. In both cases the output count, the first step tag and every extrinsic value must match a model that never saw the extra step. The following window, pushed fresh, must start from an empty stack.

// File: rtl/beta_llr_pkg.sv
package beta_llr_pkg;

    localparam int NST = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_RUN,
        ST_SAVE
    } bl_state_t;

    // feedback bit of the recursive encoder
    function automatic logic trel_fb(input logic [2:0] m, input logic j);
        return j ^ m[1] ^ m[0];
    endfunction

    function automatic logic [2:0] trel_next(input logic [2:0] m, input logic j);
        return {trel_fb(m, j), m[2], m[1]};
    endfunction

    function automatic logic trel_par(input logic [2:0] m, input logic j);
        return trel_fb(m, j) ^ m[2] ^ m[0];
    endfunction

endpackage

// File: rtl/beta_llr_gamma.sv
module beta_llr_gamma #(
    parameter int LW = 6,
    parameter int GW = LW + 2
) (
    input  logic signed [LW-1:0] apri,
    input  logic signed [LW-1:0] sys,
    input  logic signed [LW-1:0] par,
    output logic signed [GW-1:0] gam [4]
);
    // gam index is {input bit, parity bit}
    logic signed [GW-1:0] sum_sys;

    always_comb begin
        sum_sys = GW'(apri) + GW'(sys);
        gam[0]  = '0;
        gam[1]  = GW'(par);
        gam[2]  = sum_sys;
        gam[3]  = sum_sys + GW'(par);
    end
endmodule

// File: rtl/beta_llr_acs.sv
module beta_llr_acs
    import beta_llr_pkg::*;
#(
    parameter int MW   = 12,
    parameter int GW   = 8,
    parameter int LLRW = MW + 4
) (
    input  logic signed [MW-1:0]   alpha    [NST],
    input  logic signed [MW-1:0]   beta_in  [NST],
    input  logic signed [GW-1:0]   gam      [4],
    output logic signed [MW-1:0]   beta_out [NST],
    output logic signed [LLRW-1:0] llr
);
    localparam int SW = MW + 2;
    localparam int TW = MW + 3;

    logic signed [SW-1:0] bmax [NST];
    logic signed [TW-1:0] tz   [NST];
    logic signed [TW-1:0] to   [NST];

    for (genvar m = 0; m < NST; m++) begin : g_cell
        localparam logic [2:0] MS  = 3'(m);
        localparam logic [2:0] NX0 = trel_next(MS, 1'b0);
        localparam logic [2:0] NX1 = trel_next(MS, 1'b1);
        localparam logic       PB0 = trel_par(MS, 1'b0);
        localparam logic       PB1 = trel_par(MS, 1'b1);

        logic signed [SW-1:0] b0;
        logic signed [SW-1:0] b1;
        logic signed [SW:0]   nrm;

        always_comb begin
            b0      = SW'(gam[{1'b0, PB0}]) + SW'(beta_in[NX0]);
            b1      = SW'(gam[{1'b1, PB1}]) + SW'(beta_in[NX1]);
            bmax[m] = (b1 > b0) ? b1 : b0;
            tz[m]   = TW'(alpha[m]) + TW'(b0);
            to[m]   = TW'(alpha[m]) + TW'(b1);
            nrm     = (SW+1)'(bmax[m]) - (SW+1)'(bmax[0]);
            beta_out[m] = MW'(nrm);
        end
    end

    logic signed [TW-1:0] mx0;
    logic signed [TW-1:0] mx1;

    always_comb begin
        mx0 = tz[0];
        mx1 = to[0];
        for (int i = 1; i < NST; i++) begin
            if (tz[i] > mx0) mx0 = tz[i];
            if (to[i] > mx1) mx1 = to[i];
        end
        llr = LLRW'(mx1) - LLRW'(mx0);
    end
endmodule

// File: rtl/beta_llr_scale.sv
module beta_llr_scale #(
    parameter int EW = 17,
    parameter int OW = 7
) (
    input  logic signed [EW-1:0] din,
    input  logic [2:0]           sel,
    output logic signed [OW-1:0] dout
);
    localparam int OMAX = 2 ** (OW - 1) - 1;
    localparam int PWD  = EW + 4;

    logic              neg;
    logic [EW-1:0]     mag;
    logic [PWD-1:0]    m4;
    logic [PWD-1:0]    prod;
    logic [EW-1:0]     q;
    logic [OW-1:0]     qs;

    always_comb begin
        neg = din[EW-1];
        mag = neg ? EW'(-din) : EW'(din);
        m4  = PWD'(mag);
        unique case (sel)
            3'd0:    prod = (m4 << 3) + (m4 << 1);
            3'd1:    prod = (m4 << 3) + (m4 << 1) + m4;
            3'd2:    prod = (m4 << 3) + (m4 << 2);
            default: prod = (m4 << 3) + (m4 << 2) + m4;
        endcase
        q  = EW'(prod >> 4);
        qs = OW'(q);
        if (!neg) begin
            dout = (q > EW'(OMAX)) ? OW'(OMAX) : qs;
        end else begin
            dout = (q > EW'(OMAX + 1)) ? {1'b1, {(OW-1){1'b0}}} : OW'(~qs + 1'b1);
        end
    end
endmodule

// File: rtl/beta_llr_unit.sv
module beta_llr_unit
    import beta_llr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int MW    = 12,
    parameter int LW    = 6,
    parameter int OW    = 7,
    parameter int NBORD = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_valid,
    input  logic [NST*MW-1:0]            push_alpha,
    input  logic signed [LW-1:0]         push_apri,
    input  logic signed [LW-1:0]         push_sys,
    input  logic signed [LW-1:0]         push_par,
    input  logic                         start,
    input  logic                         seed_first,
    input  logic                         seed_tail,
    input  logic [$clog2(NBORD)-1:0]     load_idx,
    input  logic [$clog2(NBORD)-1:0]     save_idx,
    input  logic [2:0]                   scale_sel,
    output logic                         busy,
    output logic                         ext_valid,
    output logic signed [OW-1:0]         ext_value,
    output logic [$clog2(DEPTH)-1:0]     ext_step
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CW   = PW + 1;
    localparam int BIW  = $clog2(NBORD);
    localparam int GW   = LW + 2;
    localparam int LLRW = MW + 4;
    localparam int EW   = MW + 5;
    localparam logic signed [MW-1:0] NEG_SEED = MW'(-(2 ** (MW - 3)));

    // ---------------- state machine ----------------
    bl_state_t state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [PW-1:0]  rptr_q;
    logic           accept;
    logic           push_ok;

    assign accept  = (state_q == ST_IDLE) && start && (cnt_q != '0);
    assign push_ok = (state_q == ST_IDLE) && push_valid && !start && (cnt_q < CW'(DEPTH));
    assign busy    = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_SEED;
            ST_SEED: state_d = ST_RUN;
            ST_RUN:  if (rptr_q == '0) state_d = ST_SAVE;
            ST_SAVE: state_d = ST_IDLE;
        endcase
    end

    // ---------------- stack ----------------
    logic [NST*MW-1:0] stk_alpha [DEPTH];
    logic [LW-1:0]     stk_apri  [DEPTH];
    logic [LW-1:0]     stk_sys   [DEPTH];
    logic [LW-1:0]     stk_par   [DEPTH];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            stk_alpha[cnt_q[PW-1:0]] <= push_alpha;
            stk_apri[cnt_q[PW-1:0]]  <= push_apri;
            stk_sys[cnt_q[PW-1:0]]   <= push_sys;
            stk_par[cnt_q[PW-1:0]]   <= push_par;
        end
    end

    // ---------------- pass configuration and pointers ----------------
    logic           cfg_first_q, cfg_tail_q;
    logic [BIW-1:0] cfg_ld_q, cfg_sv_q;
    logic [2:0]     cfg_sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            rptr_q      <= '0;
            cfg_first_q <= 1'b0;
            cfg_tail_q  <= 1'b0;
            cfg_ld_q    <= '0;
            cfg_sv_q    <= '0;
            cfg_sel_q   <= '0;
        end else begin
            if (push_ok) cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_SAVE) cnt_q <= '0;
            if (accept) begin
                rptr_q      <= PW'(cnt_q - 1'b1);
                cfg_first_q <= seed_first;
                cfg_tail_q  <= seed_tail;
                cfg_ld_q    <= load_idx;
                cfg_sv_q    <= save_idx;
                cfg_sel_q   <= scale_sel;
            end else if (state_q == ST_RUN && rptr_q != '0) begin
                rptr_q <= rptr_q - 1'b1;
            end
        end
    end

    // ---------------- datapath for the current step ----------------
    logic signed [MW-1:0]   cur_alpha [NST];
    logic signed [LW-1:0]   cur_apri, cur_sys, cur_par;
    logic signed [GW-1:0]   gam [4];
    logic signed [MW-1:0]   beta_q  [NST];
    logic signed [MW-1:0]   beta_nx [NST];
    logic signed [LLRW-1:0] llr;
    logic signed [EW-1:0]   ext_raw;
    logic signed [OW-1:0]   ext_scaled;

    always_comb begin
        for (int m = 0; m < NST; m++) begin
            cur_alpha[m] = stk_alpha[rptr_q][m*MW +: MW];
        end
        cur_apri = stk_apri[rptr_q];
        cur_sys  = stk_sys[rptr_q];
        cur_par  = stk_par[rptr_q];
        ext_raw  = EW'(llr) - EW'(cur_apri) - EW'(cur_sys);
    end

    beta_llr_gamma #(.LW(LW), .GW(GW)) u_gamma (
        .apri (cur_apri),
        .sys  (cur_sys),
        .par  (cur_par),
        .gam  (gam)
    );

    beta_llr_acs #(.MW(MW), .GW(GW), .LLRW(LLRW)) u_acs (
        .alpha    (cur_alpha),
        .beta_in  (beta_q),
        .gam      (gam),
        .beta_out (beta_nx),
        .llr      (llr)
    );

    beta_llr_scale #(.EW(EW), .OW(OW)) u_scale (
        .din  (ext_raw),
        .sel  (cfg_sel_q),
        .dout (ext_scaled)
    );

    // ---------------- backward vector and border store ----------------
    logic signed [MW-1:0] bord_q [NBORD][NST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NST; m++) beta_q[m] <= '0;
        end else if (state_q == ST_SEED) begin
            for (int m = 0; m < NST; m++) begin
                if (cfg_tail_q)       beta_q[m] <= (m == 0) ? '0 : NEG_SEED;
                else if (cfg_first_q) beta_q[m] <= '0;
                else                  beta_q[m] <= bord_q[cfg_ld_q][m];
            end
        end else if (state_q == ST_RUN) begin
            for (int m = 0; m < NST; m++) beta_q[m] <= beta_nx[m];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBORD; b++)
                for (int m = 0; m < NST; m++) bord_q[b][m] <= '0;
        end else if (state_q == ST_SAVE) begin
            for (int m = 0; m < NST; m++) bord_q[cfg_sv_q][m] <= beta_q[m];
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_valid <= 1'b0;
            ext_value <= '0;
            ext_step  <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    ext_valid <= 1'b1;
                    ext_value <= ext_scaled;
                    ext_step  <= rptr_q;
                end
                default: ext_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/beta_llr_unit_chk.sv
module beta_llr_unit_chk #(
    parameter int DEPTH = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     start,
    input logic                     push_valid,
    input logic                     ext_valid,
    input logic [$clog2(DEPTH)-1:0] ext_step,
    input logic [$clog2(DEPTH):0]   cnt
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    AST_VALID_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> busy); // R2
    AST_STEP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && $past(ext_valid)) |-> (ext_step == PW'($past(ext_step) - 1'b1))); // R2
    AST_FIRST_STEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_valid) |-> (ext_step == PW'(cnt - 1'b1))); // R2
    AST_LAST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_valid) |-> ($past(ext_step) == '0)); // R2
    AST_NO_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && push_valid) |=> (cnt == $past(cnt) || cnt == '0)); // R9
    AST_NO_PUSH_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && push_valid) |=> (cnt == $past(cnt))); // R9
    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cnt == '0) |=> !busy); // R10
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R11
endmodule

bind beta_llr_unit beta_llr_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .start      (start),
    .push_valid (push_valid),
    .ext_valid  (ext_valid),
    .ext_step   (ext_step),
    .cnt        (cnt_q)
);

// File: tb/beta_llr_unit_test.sv
module beta_llr_unit_test;
    localparam int MW = 12;
    localparam int LW = 6;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [NS*MW-1:0] push_alpha = '0;
    logic signed [LW-1:0] push_apri = '0, push_sys = '0, push_par = '0;
    logic start = 1'b0, seed_first = 1'b0, seed_tail = 1'b0;
    logic [2:0] load_idx = '0, save_idx = '0, scale_sel = '0;
    logic busy, ext_valid;
    logic signed [6:0] ext_value;
    logic [5:0] ext_step;

    always #4 clk = ~clk;

    beta_llr_unit uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_alpha(push_alpha),
        .push_apri(push_apri), .push_sys(push_sys), .push_par(push_par),
        .start(start), .seed_first(seed_first), .seed_tail(seed_tail),
        .load_idx(load_idx), .save_idx(save_idx), .scale_sel(scale_sel),
        .busy(busy), .ext_valid(ext_valid), .ext_value(ext_value), .ext_step(ext_step)
    );

    int checks = 0;
    int fails = 0;
    int unsigned rng = 32'h1234_5678;
    int al [72][NS];
    int la [72], ls [72], lp [72];
    int bsave [8][NS];
    int expv [64];
    int sat_hi = 0, sat_lo = 0;

    function automatic int rnd(input int span);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng % span);
    endfunction

    function automatic int nxt(input int m, input int j);
        int a = j ^ ((m >> 1) & 1) ^ (m & 1);
        return (a << 2) | (m >> 1);
    endfunction

    function automatic int par(input int m, input int j);
        int a = j ^ ((m >> 1) & 1) ^ (m & 1);
        return a ^ ((m >> 2) & 1) ^ (m & 1);
    endfunction

    function automatic int scl(input int e, input int sel);
        int k, q, v;
        k = (sel == 0) ? 10 : (sel == 1) ? 11 : (sel == 2) ? 12 : 13;
        q = ((e < 0 ? -e : e) * k) / 16;
        v = (e < 0) ? -q : q;
        if (v > 63) v = 63;
        if (v < -64) v = -64;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gen(input int n, input int amp);
        for (int k = 0; k < n; k++) begin
            for (int m = 0; m < NS; m++) al[k][m] = rnd(2 * amp + 1) - amp;
            la[k] = rnd(64) - 32;
            ls[k] = rnd(64) - 32;
            lp[k] = rnd(64) - 32;
        end
    endtask

    // independent max-log model of one pass
    task automatic model(input int n, input bit first, input bit tail, input int ld,
                         input int sv, input int sel);
        int beta [NS];
        int bn [NS];
        for (int m = 0; m < NS; m++)
            beta[m] = tail ? ((m == 0) ? 0 : -512) : first ? 0 : bsave[ld][m];
        for (int k = n - 1; k >= 0; k--) begin
            int mx0 = -1000000, mx1 = -1000000;
            for (int m = 0; m < NS; m++) begin
                int b [2];
                for (int j = 0; j < 2; j++) begin
                    int g = (j == 1 ? la[k] + ls[k] : 0) + (par(m, j) == 1 ? lp[k] : 0);
                    b[j] = g + beta[nxt(m, j)];
                end
                bn[m] = (b[1] > b[0]) ? b[1] : b[0];
                if (al[k][m] + b[0] > mx0) mx0 = al[k][m] + b[0];
                if (al[k][m] + b[1] > mx1) mx1 = al[k][m] + b[1];
            end
            expv[k] = scl(mx1 - mx0 - la[k] - ls[k], sel);
            for (int m = 0; m < NS; m++) beta[m] = bn[m];
        end
        for (int m = 0; m < NS; m++) bsave[sv][m] = beta[m];
    endtask

    task automatic push_all(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            push_valid = 1'b1;
            for (int m = 0; m < NS; m++) push_alpha[m*MW +: MW] = MW'(al[k][m]);
            push_apri = LW'(la[k]);
            push_sys  = LW'(ls[k]);
            push_par  = LW'(lp[k]);
        end
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // mode 0: plain, 1: push held during run, 2: push together with start
    task automatic run(input int n, input bit first, input bit tail, input int ld,
                       input int sv, input int sel, input int mode, input string req);
        int eff, got, fst, cyc;
        eff = (n > 64) ? 64 : n;
        push_all(n);
        model(eff, first, tail, ld, sv, sel);
        start = 1'b1; seed_first = first; seed_tail = tail;
        load_idx = 3'(ld); save_idx = 3'(sv); scale_sel = 3'(sel);
        if (mode == 2) begin
            push_valid = 1'b1;
            push_alpha = {NS*MW{1'b1}};
        end
        @(negedge clk);
        start = 1'b0;
        push_valid = (mode == 1);
        got = 0; fst = -1; cyc = 1;
        while (cyc < eff + 20) begin
            if (ext_valid) begin
                if (fst < 0) fst = cyc;
                chk(int'(ext_step) == eff - 1 - got, "R2 step order", int'(ext_step), eff - 1 - got);
                chk(int'(ext_value) == expv[eff - 1 - got], req, int'(ext_value), expv[eff - 1 - got]);
                if (ext_value == 7'sd63) sat_hi++;
                if (ext_value == -7'sd64) sat_lo++;
                got++;
            end
            if (!busy && got > 0) break;
            @(negedge clk);
            cyc++;
        end
        push_valid = 1'b0;
        chk(got == eff, "R2 output count", got, eff);
        chk(fst == 3, "R2 first output latency", fst, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lens [4] = '{64, 1, 5, 17};
        int sel;
        for (int b = 0; b < 8; b++)
            for (int m = 0; m < NS; m++) bsave[b][m] = 0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12 busy after reset", int'(busy), 0);
        chk(ext_valid == 1'b0, "R12 ext_valid after reset", int'(ext_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: an unwritten border entry seeds zeros (entry 7, never saved)
        gen(9, 300);
        run(9, 1'b0, 1'b0, 7, 6, 2, 0, "R12 reset border entry");

        // three iterations over four windows; sweeps every scale code (R4, R6, R7, R8)
        sel = 0;
        for (int it = 0; it < 3; it++) begin
            for (int w = 0; w < 4; w++) begin
                gen(lens[w], 300);
                if (w == 3)
                    run(lens[w], it == 0, 1'b1, 0, w, sel % 8, 0, "R7 R1 R3 R4 tail seed");
                else if (it == 0)
                    run(lens[w], 1'b1, 1'b0, 0, w, sel % 8, 0, "R6 R1 R3 R4 zero seed");
                else
                    run(lens[w], 1'b0, 1'b0, w + 1, w, sel % 8, 0, "R8 R1 R3 R4 border reload");
                sel++;
            end
        end

        // R9: pushes held during a pass and together with start
        gen(12, 300);
        run(12, 1'b0, 1'b0, 1, 4, 5, 1, "R9 push during pass");
        gen(7, 300);
        run(7, 1'b0, 1'b0, 4, 5, 6, 2, "R9 push with start");

        // R10: start with empty stack
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk(busy == 1'b0, "R10 empty start busy", int'(busy), 0);
            chk(ext_valid == 1'b0, "R10 empty start output", int'(ext_valid), 0);
            @(negedge clk);
        end

        // R11: overflow, 70 pushes keep only the first 64
        gen(70, 300);
        run(70, 1'b1, 1'b0, 0, 3, 7, 0, "R11 overflow");

        // R5: large forward metric spread forces clamping
        for (int r = 0; r < 4; r++) begin
            gen(40, 1000);
            run(40, 1'b1, 1'b0, 0, 2, r, 0, "R5 saturation");
        end
        chk(sat_hi > 0, "R5 positive clamp reached", sat_hi, 1);
        chk(sat_lo > 0, "R5 negative clamp reached", sat_lo, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule